// File: doc/BRIEF.md
# Spatial Random Dither Unit

This block narrows a stream of 12-bit-per-channel RGB pixels to 6 or 8 bits per channel for an output link that carries fewer bits. When dithering is active, each channel gets a pseudo-random value added to the bits about to be dropped, and the sum is then truncated. Over an area of the picture this spreads the quantisation error as fine noise instead of visible banding. When dithering is off, or the depth code is one the unit cannot dither to, the pixel is only truncated.

The random values come from three 28-bit linear feedback shift registers, one per channel, each loaded from its own programmable seed. The generators can run as one shared source for all three channels or as three separate sources with different feedback taps. An optional per-frame reseed mixes a 4-bit frame count into the seeds. An optional high-pass mode combines each random field with the previous pixel's field on the same line.

Pixels enter and leave on valid/ready handshakes. A pixel transfers on an edge where both valid and ready are high. The output stage is a single register. `in_ready` is high when that register is empty or is being emptied in the same cycle. While `out_valid` is high and `out_ready` is low, the output pixel is held unchanged and no new pixel is taken. The configuration pins are plain levels and must stay steady while pixels are flowing. Turning dithering off for at least one cycle reloads every generator from its seed.

Top module: `spatial_dither`

## Requirements
- R1: Depth code 0 gives a 6-bit result per channel, placed in bits [7:2] of the 8-bit output with bits [1:0] zero. Depth code 1 gives an 8-bit result per channel in bits [7:0].
- R2: When `cfg_en` is low, or the depth code is 2 or 3, no dither is added. The output is the input truncated: to 6 bits for code 0 and to 8 bits for codes 1, 2 and 3. The generators are held at their seeds, the frame count at zero and the high-pass history at zero.
- R3: With `cfg_rgb_sep` low, all three channels take their random field from the red generator. That generator steps as next = {s[26:0], s[27]^s[2]}, which is the polynomial x^28+x^3+1.
- R4: With `cfg_rgb_sep` high, red, green and blue each use their own generator, loaded from `cfg_seed_r`, `cfg_seed_g` and `cfg_seed_b`. The feedback taps are s[2], s[8] and s[12] (x^28+x^3+1, x^28+x^9+1 and x^28+x^13+1).
- R5: The random field is 6 bits wide: generator bits [5:0] when `cfg_mode` is 0 and bits [27:22] when it is 1. At depth 0 all 6 bits are added to the pixel; at depth 1 only the low 4 bits are added. The 12-bit sum saturates at 4095 instead of wrapping.
- R6: While dithering is active, each generator steps exactly once for every accepted pixel and holds its state in every other cycle.
- R7: With `cfg_frame_rand` high, an accepted pixel marked `in_sof` first replaces each generator state with its seed XOR the bit-reversed 4-bit frame count (in bits [3:0]). That pixel uses the replaced state, and the count then increments, wrapping from 15 to 0. With `cfg_frame_rand` low, `in_sof` does not change the random sequence.
- R8: With `cfg_highpass` high, the added field is the current field XOR the field of the previous accepted pixel. On a pixel marked `in_sof` or `in_sol`, the previous field is taken as zero.
- R9: An accepted pixel appears on the output one cycle later. `in_ready` equals `!out_valid || out_ready`. A stalled output pixel stays stable until it is taken.
- R10: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_en | input | 1 | Dither enable |
| cfg_depth | input | 2 | Target depth: 0 = 6 bit, 1 = 8 bit, 2/3 = 8-bit truncation only |
| cfg_mode | input | 1 | Random field position: 0 = low bits, 1 = high bits |
| cfg_rgb_sep | input | 1 | Separate generator per channel |
| cfg_frame_rand | input | 1 | Reseed at every frame start |
| cfg_highpass | input | 1 | XOR with previous field on the line |
| cfg_seed_r | input | 28 | Red generator seed |
| cfg_seed_g | input | 28 | Green generator seed |
| cfg_seed_b | input | 28 | Blue generator seed |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with valid |
| in_sof | input | 1 | Pixel is first of a frame |
| in_sol | input | 1 | Pixel is first of a line |
| in_r | input | 12 | Red input |
| in_g | input | 12 | Green input |
| in_b | input | 12 | Blue input |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready |
| out_r | output | 8 | Red output |
| out_g | output | 8 | Green output |
| out_b | output | 8 | Blue output |

## Verification
The assertions rely on three things about the inputs: the configuration holds still while pixels are moving, the pixel data and frame and line marks carry defined values whenever `in_valid` is high, and a valid input is not withdrawn before it is taken. The stimulus changes configuration and seeds only after the output has drained, and only while dithering is off for two cycles. It keeps every offered pixel on the bus until it is accepted. It inserts random idle gaps and random downstream stalls, and mixes in pixels at and near full scale to reach the saturation corner.

// File: rtl/sdith_pkg.sv
package sdith_pkg;
  // generator width is fixed by the feedback polynomials
  localparam int GEN_W = 28;
  localparam int N_CH  = 3;

  typedef enum logic [1:0] {
    DEPTH_6   = 2'd0,
    DEPTH_8   = 2'd1,
    DEPTH_10  = 2'd2,
    DEPTH_RSV = 2'd3
  } depth_e;

  // low feedback tap (exponent) per channel generator
  function automatic int tap_of(input int ch);
    case (ch)
      0:       return 3;
      1:       return 9;
      default: return 13;
    endcase
  endfunction
endpackage

// File: rtl/sdith_lfsr.sv
module sdith_lfsr #(
  parameter int W       = 28,
  parameter int TAP     = 3,
  parameter int FIELD_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               adv,
  input  logic               reseed,
  input  logic [W-1:0]       seed,
  input  logic [W-1:0]       reseed_val,
  output logic [FIELD_W-1:0] fld_lo,
  output logic [FIELD_W-1:0] fld_hi
);
  logic [W-1:0] st;
  logic [W-1:0] cur;
  logic [W-1:0] nxt;

  // state used by the pixel being accepted
  assign cur    = (adv && reseed) ? reseed_val : st;
  assign nxt    = {cur[W-2:0], cur[W-1] ^ cur[TAP-1]};
  assign fld_lo = cur[FIELD_W-1:0];
  assign fld_hi = cur[W-1 -: FIELD_W];

  always_ff @(posedge clk) begin
    if (!rst_n || load) st <= seed;
    else if (adv)       st <= nxt;
  end

  property p_hold;
    @(posedge clk) disable iff (!rst_n) (!load && !adv) |=> (st == $past(st));
  endproperty
  assert_gen_hold_R6: assert property (p_hold);

  property p_load;
    @(posedge clk) disable iff (!rst_n) load |=> (st == $past(seed));
  endproperty
  assert_gen_seeded_R2: assert property (p_load);
endmodule

// File: rtl/sdith_fcnt.sv
module sdith_fcnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         bump,
  output logic [W-1:0] rev
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (bump)  cnt <= cnt + 1'b1;
  end

  always_comb begin
    for (int i = 0; i < W; i++) rev[i] = cnt[W-1-i];
  end

  property p_wrap;
    @(posedge clk) disable iff (!rst_n) (bump && !clear && cnt == '1) |=> (cnt == '0);
  endproperty
  assert_count_wrap_R7: assert property (p_wrap);

  property p_still;
    @(posedge clk) disable iff (!rst_n) (!bump && !clear) |=> $stable(cnt);
  endproperty
  assert_count_still_R7: assert property (p_still);
endmodule

// File: rtl/sdith_chan.sv
module sdith_chan #(
  parameter int IN_W     = 12,
  parameter int OUT_W    = 8,
  parameter int NARROW_W = 6,
  localparam int DROP_N  = IN_W - NARROW_W,
  localparam int DROP_W  = IN_W - OUT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              active,
  input  logic              narrow,
  input  logic              hp,
  input  logic              line_start,
  input  logic [DROP_N-1:0] field,
  input  logic [IN_W-1:0]   pix,
  output logic [OUT_W-1:0]  res
);
  logic [DROP_N-1:0] prev;
  logic [DROP_N-1:0] hist;
  logic [DROP_N-1:0] d6;
  logic [IN_W-1:0]   dith;
  logic [IN_W:0]     sum;
  logic [IN_W-1:0]   sat;
  logic [OUT_W-1:0]  res_d;

  always_comb begin
    hist = line_start ? '0 : prev;
    d6   = hp ? (field ^ hist) : field;
    dith = '0;
    if (active) dith = narrow ? IN_W'(d6) : IN_W'(d6[DROP_W-1:0]);
    sum  = {1'b0, pix} + {1'b0, dith};
    sat  = sum[IN_W] ? '1 : sum[IN_W-1:0];
    res_d = narrow ? {sat[IN_W-1 -: NARROW_W], {(OUT_W-NARROW_W){1'b0}}}
                   : sat[IN_W-1 -: OUT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev <= '0;
    else if (!active) prev <= '0;
    else if (take)    prev <= field;
  end

  always_ff @(posedge clk) begin
    if (take) res <= res_d;
  end

  // saturating sum never falls below the input and pins at full scale
  property p_sat;
    @(posedge clk) disable iff (!rst_n)
      take |-> ((sat >= pix) && (!sum[IN_W] || sat == '1));
  endproperty
  assert_sat_floor_R5: assert property (p_sat);

  property p_step;
    @(posedge clk) disable iff (!rst_n)
      take |-> (narrow ? ((res_d >> (OUT_W-NARROW_W)) - OUT_W'(pix >> DROP_N) <= 1)
                       : ((res_d - OUT_W'(pix >> DROP_W)) <= 1));
  endproperty
  assert_one_level_R5: assert property (p_step);

  property p_narrow;
    @(posedge clk) disable iff (!rst_n)
      (take && narrow) |=> (res[OUT_W-NARROW_W-1:0] == '0);
  endproperty
  assert_low_bits_zero_R1: assert property (p_narrow);

  property p_plain;
    @(posedge clk) disable iff (!rst_n)
      (take && !active && !narrow) |=> (res == $past(pix[IN_W-1 -: OUT_W]));
  endproperty
  assert_plain_trunc_R2: assert property (p_plain);
endmodule

// File: rtl/spatial_dither.sv
module spatial_dither
  import sdith_pkg::*;
#(
  parameter int IN_W     = 12,
  parameter int OUT_W    = 8,
  parameter int NARROW_W = 6,
  parameter int FCNT_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic [1:0]       cfg_depth,
  input  logic             cfg_mode,
  input  logic             cfg_rgb_sep,
  input  logic             cfg_frame_rand,
  input  logic             cfg_highpass,
  input  logic [GEN_W-1:0] cfg_seed_r,
  input  logic [GEN_W-1:0] cfg_seed_g,
  input  logic [GEN_W-1:0] cfg_seed_b,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sof,
  input  logic             in_sol,
  input  logic [IN_W-1:0]  in_r,
  input  logic [IN_W-1:0]  in_g,
  input  logic [IN_W-1:0]  in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_r,
  output logic [OUT_W-1:0] out_g,
  output logic [OUT_W-1:0] out_b
);
  localparam int DROP_N = IN_W - NARROW_W;

  logic take;
  logic active;
  logic narrow;
  logic fr_hit;
  logic [FCNT_W-1:0] frev;

  logic [GEN_W-1:0]  seed_a [N_CH];
  logic [IN_W-1:0]   pix_a  [N_CH];
  logic [OUT_W-1:0]  res_a  [N_CH];
  logic [DROP_N-1:0] lo_a   [N_CH];
  logic [DROP_N-1:0] hi_a   [N_CH];
  logic [DROP_N-1:0] fld_a  [N_CH];

  assign seed_a[0] = cfg_seed_r;
  assign seed_a[1] = cfg_seed_g;
  assign seed_a[2] = cfg_seed_b;
  assign pix_a[0]  = in_r;
  assign pix_a[1]  = in_g;
  assign pix_a[2]  = in_b;
  assign out_r     = res_a[0];
  assign out_g     = res_a[1];
  assign out_b     = res_a[2];

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign narrow   = (cfg_depth == DEPTH_6);
  assign active   = cfg_en && ((cfg_depth == DEPTH_6) || (cfg_depth == DEPTH_8));
  assign fr_hit   = cfg_frame_rand && in_sof;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         out_valid <= 1'b0;
    else if (take)      out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end

  sdith_fcnt #(.W(FCNT_W)) u_fcnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (!active),
    .bump  (take && active && fr_hit),
    .rev   (frev)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    sdith_lfsr #(.W(GEN_W), .TAP(tap_of(c)), .FIELD_W(DROP_N)) u_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (!active),
      .adv        (take && active),
      .reseed     (fr_hit),
      .seed       (seed_a[c]),
      .reseed_val (seed_a[c] ^ {{(GEN_W-FCNT_W){1'b0}}, frev}),
      .fld_lo     (lo_a[c]),
      .fld_hi     (hi_a[c])
    );

    // shared mode feeds every channel from the red generator
    assign fld_a[c] = cfg_mode ? (cfg_rgb_sep ? hi_a[c] : hi_a[0])
                               : (cfg_rgb_sep ? lo_a[c] : lo_a[0]);

    sdith_chan #(.IN_W(IN_W), .OUT_W(OUT_W), .NARROW_W(NARROW_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (take),
      .active     (active),
      .narrow     (narrow),
      .hp         (cfg_highpass),
      .line_start (in_sof || in_sol),
      .field      (fld_a[c]),
      .pix        (pix_a[c]),
      .res        (res_a[c])
    );
  end

  property p_accept;
    @(posedge clk) disable iff (!rst_n) take |=> out_valid;
  endproperty
  assert_accept_latency_R9: assert property (p_accept);

  property p_stall;
    @(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable({out_r, out_g, out_b}));
  endproperty
  assert_stall_hold_R9: assert property (p_stall);

  property p_drain;
    @(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !in_valid) |=> !out_valid;
  endproperty
  assert_drain_R9: assert property (p_drain);
endmodule

// File: tb/spatial_dither_test.sv
module spatial_dither_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        cfg_en, cfg_mode, cfg_rgb_sep, cfg_frame_rand, cfg_highpass;
  logic [1:0]  cfg_depth;
  logic [27:0] seed [3];
  logic        in_valid, in_ready, in_sof, in_sol;
  logic [11:0] in_r, in_g, in_b;
  logic        out_valid, out_ready;
  logic [7:0]  out_r, out_g, out_b;

  spatial_dither uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_depth(cfg_depth),
    .cfg_mode(cfg_mode), .cfg_rgb_sep(cfg_rgb_sep), .cfg_frame_rand(cfg_frame_rand),
    .cfg_highpass(cfg_highpass), .cfg_seed_r(seed[0]), .cfg_seed_g(seed[1]),
    .cfg_seed_b(seed[2]), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_sol(in_sol), .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  string tag;
  logic [23:0] expq[$];
  logic [27:0] m_st [3];
  logic [3:0]  m_cnt;
  logic [5:0]  m_prev [3];
  logic        stall_pend = 0;
  logic [23:0] stall_data;

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic int tap_for(input int c);
    return (c == 0) ? 3 : (c == 1) ? 9 : 13;
  endfunction

  function automatic logic [27:0] gen_step(input logic [27:0] s, input int tap);
    return {s[26:0], s[27] ^ s[tap-1]};
  endfunction

  task automatic model_clear();
    for (int c = 0; c < 3; c++) begin
      m_st[c] = seed[c];
      m_prev[c] = '0;
    end
    m_cnt = '0;
  endtask

  task automatic model_pixel(input logic sof, input logic sol,
                             input logic [11:0] r, input logic [11:0] g,
                             input logic [11:0] b, output logic [23:0] o);
    logic [11:0] px [3];
    logic [7:0]  ov [3];
    logic [27:0] st [3];
    logic [27:0] src;
    logic [5:0]  fld, pu, d6;
    logic [12:0] sum;
    logic [3:0]  rv;
    bit act, nar;
    px[0] = r; px[1] = g; px[2] = b;
    act = cfg_en && (cfg_depth < 2);
    nar = (cfg_depth == 0);
    if (!act) begin
      for (int c = 0; c < 3; c++) ov[c] = nar ? {px[c][11:6], 2'b00} : px[c][11:4];
      model_clear();
    end else begin
      rv = {m_cnt[0], m_cnt[1], m_cnt[2], m_cnt[3]};
      for (int c = 0; c < 3; c++)
        st[c] = (cfg_frame_rand && sof) ? (seed[c] ^ {24'd0, rv}) : m_st[c];
      for (int c = 0; c < 3; c++) begin
        src = cfg_rgb_sep ? st[c] : st[0];
        fld = cfg_mode ? src[27:22] : src[5:0];
        pu  = (sof || sol) ? 6'd0 : m_prev[c];
        d6  = cfg_highpass ? (fld ^ pu) : fld;
        m_prev[c] = fld;
        sum = {1'b0, px[c]} + (nar ? {7'd0, d6} : {9'd0, d6[3:0]});
        if (sum > 13'd4095) sum = 13'd4095;
        ov[c] = nar ? {sum[11:6], 2'b00} : sum[11:4];
      end
      for (int c = 0; c < 3; c++) m_st[c] = gen_step(st[c], tap_for(c));
      if (cfg_frame_rand && sof) m_cnt = m_cnt + 1'b1;
    end
    o = {ov[0], ov[1], ov[2]};
  endtask

  // one clock: output side observed, then input driven, away from the edge
  task automatic tick(input logic drv, input logic sof, input logic sol,
                      input logic [11:0] r, input logic [11:0] g, input logic [11:0] b,
                      input logic force_rdy, output logic acc);
    logic [23:0] e;
    logic [23:0] cur;
    @(negedge clk);
    out_ready = force_rdy ? 1'b1 : (($urandom % 4) != 0);
    #1;
    cur = {out_r, out_g, out_b};
    if (stall_pend) check("R9 stall", {7'd0, out_valid, cur}, {8'd1, stall_data});
    if (out_valid && out_ready) begin
      if (expq.size() == 0) check("R9 spurious", 32'd1, 32'd0);
      else begin
        e = expq.pop_front();
        check(tag, {8'd0, cur}, {8'd0, e});
      end
    end
    stall_pend = out_valid && !out_ready;
    stall_data = cur;
    in_valid = drv; in_sof = sof; in_sol = sol;
    in_r = r; in_g = g; in_b = b;
    #1;
    acc = drv && in_ready;
    if (acc) begin
      model_pixel(sof, sol, r, g, b, e);
      expq.push_back(e);
    end
  endtask

  task automatic idle(input logic force_rdy);
    logic a;
    tick(1'b0, 1'b0, 1'b0, 12'd0, 12'd0, 12'd0, force_rdy, a);
  endtask

  function automatic logic [11:0] pick_px(input bit hot);
    int k;
    k = $urandom % 8;
    if (hot && k < 3) return 12'hFFF - 12'($urandom % 24);
    if (k == 0) return 12'd0;
    if (k == 1) return 12'hFFF;
    return 12'($urandom);
  endfunction

  task automatic run_seg(input string t, input logic en, input logic [1:0] dp,
                         input logic md, input logic sep, input logic fr, input logic hp,
                         input int frames, input int lines, input int ppl,
                         input int gap_pct, input bit hot);
    logic a;
    while (expq.size() != 0) idle(1'b1);
    idle(1'b1);
    cfg_en = 1'b0;
    cfg_depth = dp; cfg_mode = md; cfg_rgb_sep = sep;
    cfg_frame_rand = fr; cfg_highpass = hp;
    for (int c = 0; c < 3; c++) seed[c] = 28'($urandom) | 28'd1;
    idle(1'b1);
    idle(1'b1);
    tag = t;
    model_clear();
    cfg_en = en;
    for (int f = 0; f < frames; f++)
      for (int l = 0; l < lines; l++)
        for (int p = 0; p < ppl; p++) begin
          logic [11:0] r, g, b;
          r = pick_px(hot); g = pick_px(hot); b = pick_px(hot);
          if (($urandom % 100) < gap_pct) idle(1'b0);
          do tick(1'b1, (l == 0 && p == 0), (p == 0), r, g, b, 1'b0, a);
          while (!a);
        end
    while (expq.size() != 0) idle(1'b1);
    idle(1'b1);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!finished && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R9 watchdog actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd9127));
    rst_n = 1'b0;
    cfg_en = 0; cfg_depth = 0; cfg_mode = 0; cfg_rgb_sep = 0;
    cfg_frame_rand = 0; cfg_highpass = 0;
    for (int c = 0; c < 3; c++) seed[c] = 28'h1;
    in_valid = 0; in_sof = 0; in_sol = 0; in_r = 0; in_g = 0; in_b = 0;
    out_ready = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R10 out_valid", {31'd0, out_valid}, 32'd0);
    check("R10 in_ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R10 out_valid after release", {31'd0, out_valid}, 32'd0);
    check("R10 in_ready after release", {31'd0, in_ready}, 32'd1);

    run_seg("R2 disabled depth0",    0, 2'd0, 0, 0, 0, 0, 1, 3, 6, 20, 1);
    run_seg("R2 depth code 2",       1, 2'd2, 0, 1, 1, 1, 2, 2, 5, 20, 1);
    run_seg("R2 depth code 3",       1, 2'd3, 1, 0, 0, 1, 1, 2, 5, 20, 0);
    run_seg("R1 R3 shared depth0",   1, 2'd0, 0, 0, 0, 0, 1, 4, 8, 10, 0);
    run_seg("R1 R3 shared depth1",   1, 2'd1, 0, 0, 0, 0, 1, 4, 8, 10, 0);
    run_seg("R4 separate depth1",    1, 2'd1, 0, 1, 0, 0, 1, 4, 8, 10, 0);
    run_seg("R4 separate depth0",    1, 2'd0, 0, 1, 0, 0, 1, 4, 8, 10, 0);
    run_seg("R5 high field sat",     1, 2'd0, 1, 1, 0, 0, 1, 4, 8, 10, 1);
    run_seg("R5 depth1 sat",         1, 2'd1, 1, 0, 0, 0, 1, 4, 8, 10, 1);
    run_seg("R6 idle gaps",          1, 2'd0, 0, 1, 0, 0, 1, 3, 10, 60, 0);
    run_seg("R7 frame reseed",       1, 2'd0, 0, 1, 1, 0, 18, 2, 3, 10, 0);
    run_seg("R7 sof ignored",        1, 2'd1, 1, 1, 0, 0, 4, 2, 4, 10, 0);
    run_seg("R8 highpass",           1, 2'd0, 0, 1, 0, 1, 2, 4, 6, 10, 0);
    run_seg("R8 highpass shared fr", 1, 2'd1, 1, 0, 1, 1, 5, 3, 4, 20, 1);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule